// File: doc/BRIEF.md
# AES3 Channel-Status and User-Bit Source

This block supplies the C (channel status), U (user) and V (validity) bits that an AES3 transmitter places in each subframe. It watches the output frame clock `fsync`. A rising edge opens the left subframe of a frame and a falling edge opens the right subframe. On every such edge it presents one set of C, U and V bits together with a one-cycle strobe. It also counts frames within the 192-frame channel-status block. Depending on a direction setting taken at reset, it either announces the first frame of each block on `blk_start_o` or takes the block boundary from `blk_start_i`.

The `mode_serial` pin selects the bit source.

- **Pattern mode (low):** C follows a fixed 192-bit status block chosen by the two control pins, and U and V are zero.
- **Serial mode (high):** the three control pins are passed straight through, one sample per frame-clock edge.

Bits flow out as a strobed stream, `sf_valid` with the C, U and V bits. There is no ready signal: the frame clock paces the stream, so the transmitter must accept the bits in the cycle `sf_valid` is high, and no back-pressure is possible. Each level of `fsync` must be held for at least two `clk` cycles. `fsync` and the control pins are assumed synchronous to `clk`.

Top module: `csu_cuv_source`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sf_valid`, `sf_left`, `c_bit`, `u_bit`, `v_bit` and `blk_start_o` are 0. The frame count is 0. Every subframe delivered before the first block start carries C=U=V=0.
- R2: A change of `fsync` is seen at the first `clk` edge that samples the new level. At that edge `sf_valid` becomes 1 for exactly one cycle. At the same edge `sf_left` becomes 1 for a rising edge (left subframe) and 0 for a falling edge (right subframe).
- R3: With the output direction latched, the first rising `fsync` edge after reset starts frame 0. The frame index then steps by one on each rising edge and wraps from 191 to 0. `blk_start_o` is 1 from the left-subframe strobe of frame 0 until the next rising edge, and 0 otherwise.
- R4: With the input direction latched, a rising `fsync` edge that samples `blk_start_i` high starts frame 0. This applies only when `blk_start_i` was low at the previous rising edge. It also resynchronises a running count. `blk_start_o` stays 0.
- R5: The block-start direction is taken from `blk_dir_in` (1 = input) while `rst` is high. Changes of `blk_dir_in` after reset have no effect.
- R6: Pattern mode, consumer format (`{dat_c_or_cpy,dat_u_or_gen}` = 00, 01 or 10), gives C = bit n of the block in frame n.
  - Bit 0 is 0.
  - Bit 2 is 1 unless the pins are 10 (copy inhibited).
  - Bits 9, 11 and 12 are 1. These are bits 8 to 14 holding category 0101100, read with bit 8 first.
  - Bit 15 equals `dat_u_or_gen`.
  - Every other bit is 0.
- R7: Pattern mode with pins 11 (professional format) gives C=1 only in frame 0. Every other frame carries C=0.
- R8: In pattern mode `u_bit` and `v_bit` are 0 on every subframe, whatever `dat_v` and the other pins carry.
- R9: In pattern mode the left and right subframes of one frame carry the same C bit.
- R10: In serial mode, `c_bit`, `u_bit` and `v_bit` equal `dat_c_or_cpy`, `dat_u_or_gen` and `dat_v`, sampled at the same `clk` edge that sees the `fsync` change. This holds once a block start has occurred.
- R11: `mode_serial` and the control pins are read afresh at every subframe. Switching mode mid-block does not disturb the frame count or the block-start timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also latches `blk_dir_in` |
| mode_serial | input | 1 | 0 = pattern mode, 1 = serial pass-through mode |
| blk_dir_in | input | 1 | Start-up direction of the block-start signal, 1 = input |
| fsync | input | 1 | Output frame clock; high = left subframe |
| dat_c_or_cpy | input | 1 | Pattern mode: format/copy select; serial mode: C bit |
| dat_u_or_gen | input | 1 | Pattern mode: format/generation select; serial mode: U bit |
| dat_v | input | 1 | Serial mode: V bit; ignored in pattern mode |
| blk_start_i | input | 1 | Block-start marker when the input direction is latched |
| sf_valid | output | 1 | One-cycle strobe per subframe |
| sf_left | output | 1 | 1 when the strobed subframe is a left subframe |
| c_bit | output | 1 | Channel-status bit for the subframe |
| u_bit | output | 1 | User bit for the subframe |
| v_bit | output | 1 | Validity bit for the subframe |
| blk_start_o | output | 1 | High during frame 0 when the output direction is latched |

## Verification
The frame-count wrap and a block-start resynchronisation can coincide on one rising `fsync` edge. So can a mode switch and a block boundary. The bench pulses `blk_start_i` in the frame where the count would wrap anyway. It also does so mid-block, and flips `mode_serial` while frames near 0 and 191 are passing. A behavioural model with its own frame count predicts the strobe, the left flag, each bit and `blk_start_o` on every clock. From that model the bench judges that the count restarts exactly once, and that C follows the mode in force at that subframe.

// File: rtl/csu_pkg.sv
package csu_pkg;

  typedef enum logic [1:0] {
    CS_CONS_FREE   = 2'b00,
    CS_CONS_GEN    = 2'b01,
    CS_CONS_NOCOPY = 2'b10,
    CS_PRO         = 2'b11
  } cs_sel_e;

  typedef struct packed {
    logic c;
    logic u;
    logic v;
  } cuv_t;

endpackage

// File: rtl/csu_frame_edge.sv
module csu_frame_edge (
  input  logic clk,
  input  logic rst,
  input  logic fsync,
  output logic rise,
  output logic fall
);
  logic fsync_q;

  always_ff @(posedge clk) begin
    if (rst) fsync_q <= 1'b0;
    else     fsync_q <= fsync;
  end

  assign rise = !rst && fsync && !fsync_q;
  assign fall = !rst && !fsync && fsync_q;
endmodule

// File: rtl/csu_block_count.sv
module csu_block_count #(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  localparam int unsigned IDX_W = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_in,
  input  logic             rise,
  input  logic             bs_in,
  output logic [IDX_W-1:0] frame_nxt,
  output logic             started_nxt,
  output logic [IDX_W-1:0] frame_q,
  output logic             started_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES_PER_BLOCK - 1);

  logic             bs_q;
  logic             bs_nxt;
  logic [IDX_W-1:0] frame_wrap;

  assign frame_wrap = (frame_q == LAST) ? '0 : frame_q + 1'b1;

  always_comb begin
    frame_nxt   = frame_q;
    started_nxt = started_q;
    bs_nxt      = bs_q;
    if (rise) begin
      bs_nxt = bs_in;
      if (dir_in) begin
        if (bs_in && !bs_q) begin
          frame_nxt   = '0;
          started_nxt = 1'b1;
        end else if (started_q) begin
          frame_nxt = frame_wrap;
        end
      end else if (!started_q) begin
        frame_nxt   = '0;
        started_nxt = 1'b1;
      end else begin
        frame_nxt = frame_wrap;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q   <= '0;
      started_q <= 1'b0;
      bs_q      <= 1'b0;
    end else begin
      frame_q   <= frame_nxt;
      started_q <= started_nxt;
      bs_q      <= bs_nxt;
    end
  end
endmodule

// File: rtl/csu_cs_pattern.sv
module csu_cs_pattern
  import csu_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  parameter int unsigned CAT_W    = 7,
  parameter int unsigned CAT_BASE = 8,
  parameter logic [CAT_W-1:0] CAT_CODE = 7'b0011010,
  parameter int unsigned COPY_POS = 2,
  parameter int unsigned GEN_POS  = 15,
  localparam int unsigned IDX_W = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic [IDX_W-1:0] idx,
  input  cs_sel_e          sel,
  output logic             c
);
  logic [CAT_W-1:0] cat_hit;

  for (genvar k = 0; k < CAT_W; k++) begin : g_cat
    assign cat_hit[k] = (idx == IDX_W'(CAT_BASE + k)) && CAT_CODE[k];
  end

  always_comb begin
    c = 1'b0;
    if (sel == CS_PRO) begin
      c = (idx == '0);
    end else begin
      if (idx == IDX_W'(COPY_POS)) c = (sel != CS_CONS_NOCOPY);
      if (idx == IDX_W'(GEN_POS))  c = (sel == CS_CONS_GEN);
      if (|cat_hit)                c = 1'b1;
    end
  end
endmodule

// File: rtl/csu_cuv_source.sv
module csu_cuv_source
  import csu_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  parameter int unsigned CAT_W    = 7,
  parameter int unsigned CAT_BASE = 8,
  parameter logic [CAT_W-1:0] CAT_CODE = 7'b0011010,
  parameter int unsigned COPY_POS = 2,
  parameter int unsigned GEN_POS  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_serial,
  input  logic blk_dir_in,
  input  logic fsync,
  input  logic dat_c_or_cpy,
  input  logic dat_u_or_gen,
  input  logic dat_v,
  input  logic blk_start_i,
  output logic sf_valid,
  output logic sf_left,
  output logic c_bit,
  output logic u_bit,
  output logic v_bit,
  output logic blk_start_o
);
  localparam int unsigned IDX_W = $clog2(FRAMES_PER_BLOCK);

  logic             dir_q;
  logic             rise;
  logic             fall;
  logic [IDX_W-1:0] frame_nxt;
  logic [IDX_W-1:0] frame_idx;
  logic             started_nxt;
  logic             blk_started;
  logic             pat_c;
  cuv_t             cuv_sel;

  // Direction is a start-up setting: sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) dir_q <= blk_dir_in;
  end

  csu_frame_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .fsync(fsync),
    .rise (rise),
    .fall (fall)
  );

  csu_block_count #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_count (
    .clk        (clk),
    .rst        (rst),
    .dir_in     (dir_q),
    .rise       (rise),
    .bs_in      (blk_start_i),
    .frame_nxt  (frame_nxt),
    .started_nxt(started_nxt),
    .frame_q    (frame_idx),
    .started_q  (blk_started)
  );

  csu_cs_pattern #(
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK),
    .CAT_W   (CAT_W),
    .CAT_BASE(CAT_BASE),
    .CAT_CODE(CAT_CODE),
    .COPY_POS(COPY_POS),
    .GEN_POS (GEN_POS)
  ) u_pat (
    .idx(frame_nxt),
    .sel(cs_sel_e'({dat_c_or_cpy, dat_u_or_gen})),
    .c  (pat_c)
  );

  always_comb begin
    if (!started_nxt)     cuv_sel = '0;
    else if (mode_serial) cuv_sel = '{c: dat_c_or_cpy, u: dat_u_or_gen, v: dat_v};
    else                  cuv_sel = '{c: pat_c, u: 1'b0, v: 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_valid    <= 1'b0;
      sf_left     <= 1'b0;
      c_bit       <= 1'b0;
      u_bit       <= 1'b0;
      v_bit       <= 1'b0;
      blk_start_o <= 1'b0;
    end else begin
      sf_valid <= rise | fall;
      if (rise | fall) begin
        sf_left <= rise;
        c_bit   <= cuv_sel.c;
        u_bit   <= cuv_sel.u;
        v_bit   <= cuv_sel.v;
      end
      if (rise) blk_start_o <= !dir_q && started_nxt && (frame_nxt == '0);
    end
  end
endmodule

module csu_cuv_source_chk #(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  localparam int unsigned IDX_W = $clog2(FRAMES_PER_BLOCK)
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_serial,
  input logic             dat_c_or_cpy,
  input logic             dat_u_or_gen,
  input logic             dat_v,
  input logic             sf_valid,
  input logic             sf_left,
  input logic             c_bit,
  input logic             u_bit,
  input logic             v_bit,
  input logic             blk_start_o,
  input logic             dir_q,
  input logic             blk_started,
  input logic [IDX_W-1:0] frame_idx
);
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    sf_valid |=> !sf_valid);

  p_start_on_left_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_start_o) |-> sf_valid && sf_left);

  p_frame_bound_r3: assert property (@(posedge clk) disable iff (rst)
    frame_idx <= IDX_W'(FRAMES_PER_BLOCK - 1));

  p_no_start_out_r4: assert property (@(posedge clk) disable iff (rst)
    dir_q |-> !blk_start_o);

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dir_q));

  p_uv_zero_r8: assert property (@(posedge clk) disable iff (rst)
    sf_valid && !$past(mode_serial) |-> !u_bit && !v_bit);

  p_serial_follow_r10: assert property (@(posedge clk) disable iff (rst)
    sf_valid && $past(mode_serial) && $past(blk_started) |->
      c_bit == $past(dat_c_or_cpy) && u_bit == $past(dat_u_or_gen) && v_bit == $past(dat_v));
endmodule

bind csu_cuv_source csu_cuv_source_chk #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_serial (mode_serial),
  .dat_c_or_cpy(dat_c_or_cpy),
  .dat_u_or_gen(dat_u_or_gen),
  .dat_v       (dat_v),
  .sf_valid    (sf_valid),
  .sf_left     (sf_left),
  .c_bit       (c_bit),
  .u_bit       (u_bit),
  .v_bit       (v_bit),
  .blk_start_o (blk_start_o),
  .dir_q       (dir_q),
  .blk_started (blk_started),
  .frame_idx   (frame_idx)
);

// File: tb/csu_cuv_source_tb.sv
module csu_cuv_source_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_serial = 1'b0;
  logic blk_dir_in = 1'b0;
  logic fsync = 1'b0;
  logic dat_c_or_cpy = 1'b0;
  logic dat_u_or_gen = 1'b0;
  logic dat_v = 1'b0;
  logic blk_start_i = 1'b0;
  logic sf_valid, sf_left, c_bit, u_bit, v_bit, blk_start_o;

  int n_checks = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;
  string phase_tag = "";

  always #4 clk = ~clk;

  csu_cuv_source dut_i (
    .clk(clk), .rst(rst), .mode_serial(mode_serial), .blk_dir_in(blk_dir_in),
    .fsync(fsync), .dat_c_or_cpy(dat_c_or_cpy), .dat_u_or_gen(dat_u_or_gen),
    .dat_v(dat_v), .blk_start_i(blk_start_i), .sf_valid(sf_valid), .sf_left(sf_left),
    .c_bit(c_bit), .u_bit(u_bit), .v_bit(v_bit), .blk_start_o(blk_start_o)
  );

  // Behavioural reference model
  int m_dir, m_prev, m_started, m_frame, m_bsprev;
  logic e_valid = 0, e_left = 0, e_c = 0, e_u = 0, e_v = 0, e_bs = 0;
  string t_c = "R1", t_uv = "R1", t_bs = "R1", t_vl = "R1";

  function automatic logic ref_c(int idx, logic a, logic b);
    string cat = "0101100";
    if (a && b) return idx == 0;          // R7 professional
    if (idx == 2) return !(a && !b);       // R6 copy permitted
    if (idx >= 8 && idx <= 14) return cat[idx-8] == 8'd49;
    if (idx == 15) return b;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_dir = blk_dir_in; m_prev = 0; m_started = 0; m_frame = 0; m_bsprev = 0;
      e_valid = 0; e_left = 0; e_c = 0; e_u = 0; e_v = 0; e_bs = 0;
      t_c = "R1"; t_uv = "R1"; t_bs = "R1"; t_vl = "R1";
    end else begin
      int rise_e, fall_e;
      rise_e = fsync && !m_prev;
      fall_e = !fsync && m_prev;
      m_prev = fsync;
      t_vl = "R2";
      if (rise_e) begin
        if (m_dir != 0) begin
          if (blk_start_i && !m_bsprev) begin m_frame = 0; m_started = 1; end
          else if (m_started != 0) m_frame = (m_frame + 1) % 192;
        end else begin
          if (m_started == 0) begin m_frame = 0; m_started = 1; end
          else m_frame = (m_frame + 1) % 192;
        end
        m_bsprev = blk_start_i;
        e_bs = (m_dir == 0) && (m_started != 0) && (m_frame == 0);
        t_bs = (phase_tag != "") ? phase_tag : ((m_dir != 0) ? "R4" : "R3");
      end
      e_valid = rise_e || fall_e;
      if (rise_e || fall_e) begin
        e_left = rise_e;
        if (m_started == 0) begin
          e_c = 0; e_u = 0; e_v = 0; t_c = "R1"; t_uv = "R1";
        end else if (mode_serial) begin
          e_c = dat_c_or_cpy; e_u = dat_u_or_gen; e_v = dat_v;
          t_c = (phase_tag == "R11") ? "R11" : "R10"; t_uv = "R10";
        end else begin
          e_c = ref_c(m_frame, dat_c_or_cpy, dat_u_or_gen);
          e_u = 0; e_v = 0; t_uv = "R8";
          if (phase_tag == "R11") t_c = "R11";
          else if (fall_e) t_c = "R9";
          else t_c = (dat_c_or_cpy && dat_u_or_gen) ? "R7" : "R6";
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(t_vl, "sf_valid", sf_valid, e_valid);
      chk(t_vl, "sf_left", sf_left, e_left);
      chk(t_c, "c_bit", c_bit, e_c);
      chk(t_uv, "u_bit", u_bit, e_u);
      chk(t_uv, "v_bit", v_bit, e_v);
      chk(t_bs, "blk_start_o", blk_start_o, e_bs);
    end
  end

  // One frame = 8 clocks; pins may be re-randomised at each half.
  task automatic run_frames(input int n, input bit rnd, input int bs_at);
    for (int f = 0; f < n; f++) begin
      for (int h = 0; h < 2; h++) begin
        @(negedge clk); #1;
        fsync = (h == 0);
        if (h == 0) blk_start_i = (f == bs_at);
        if (rnd) begin
          dat_c_or_cpy = 1'($urandom); dat_u_or_gen = 1'($urandom); dat_v = 1'($urandom);
        end else begin
          dat_v = 1'($urandom);
        end
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic do_reset(input logic dir);
    @(negedge clk); #1;
    rst = 1; blk_dir_in = dir; fsync = 0; blk_start_i = 0;
    repeat (3) @(negedge clk);
    #1 rst = 0;
  endtask

  initial begin
    // R1: reset state, checked each clock by the model
    do_reset(1'b0);
    repeat (4) @(negedge clk);
    // R6, R9: consumer variants, full block and wrap (R3)
    mode_serial = 0;
    dat_c_or_cpy = 0; dat_u_or_gen = 0; run_frames(200, 0, -1);
    dat_c_or_cpy = 0; dat_u_or_gen = 1; run_frames(200, 0, -1);
    dat_c_or_cpy = 1; dat_u_or_gen = 0; run_frames(200, 0, -1);
    // R7: professional
    dat_c_or_cpy = 1; dat_u_or_gen = 1; run_frames(200, 0, -1);
    // R10: serial pass-through
    mode_serial = 1; run_frames(60, 1, -1);
    // R11: mode toggles around the block boundary
    phase_tag = "R11";
    for (int k = 0; k < 12; k++) begin
      mode_serial = k[0];
      run_frames(7, k[0], -1);
    end
    phase_tag = "";
    // R5: direction pin changed after reset has no effect
    mode_serial = 0; dat_c_or_cpy = 0; dat_u_or_gen = 1;
    phase_tag = "R5"; blk_dir_in = 1;
    run_frames(200, 0, -1);
    phase_tag = "";
    // R4: input direction, C held at zero until block start (R1)
    do_reset(1'b1);
    run_frames(20, 0, -1);
    run_frames(100, 0, 5);
    run_frames(200, 0, 187);   // resync in the frame where wrap is also due
    run_frames(50, 0, 30);
    mode_serial = 1; run_frames(30, 1, 10);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule